// File: doc/BRIEF.md
# Segmented Physical Address Generator

This unit forms a 20-bit physical byte address from a 16-bit offset and a memory reference kind. It keeps four 16-bit segment base registers (code, stack, data, extra). Each reference kind has a fixed default base. Three kinds may have their base replaced by a requested override. The other three always use their own base. An override sent with a locked kind is dropped, and a flag reports the rejection. The final address is the selected base shifted left by four, plus the offset. The sum wraps inside the 1 MiB space.

The client sends one request per clock: a kind code, an offset and an optional override. One cycle later it reads the registered address and the rejection flag. Segment bases are loaded through a single write port. A write becomes visible to requests sampled from the next clock edge onward.

Top module: `seg_addr_gen`

## Requirements
- R1: `phys_addr` equals (base × 16 + offset) modulo 2^20. It appears at the clock edge that samples the request, so it is valid one cycle after the request is driven. Its low four bits always equal the request's low four offset bits.
- R2: Kind code 0 (instruction fetch) always uses the code base. A requested override is ignored and `ovr_rejected` is set.
- R3: Kind code 1 (stack operation) always uses the stack base. A requested override is ignored and `ovr_rejected` is set.
- R4: Kind code 2 (general variable) defaults to the data base. When `ovr_req` is high it uses the base chosen by `ovr_sel`, and `ovr_rejected` stays low.
- R5: Kind code 3 (string source) defaults to the data base and accepts an override in the same way as R4.
- R6: Kind code 4 (string destination) always uses the extra base. A requested override is ignored and `ovr_rejected` is set.
- R7: Kind code 5 (base-pointer based reference) defaults to the stack base and accepts an override, with `ovr_rejected` low.
- R8: A sum at or above 2^20 drops its carry. For example, base FFFFh with offset FFFFh gives 0FFEFh.
- R9: A segment write sampled at edge t affects requests sampled from edge t+1 onward. A request sampled at the same edge t still sees the old base.
- R10: Reset clears all four bases, `phys_addr` and `ovr_rejected` to zero.
- R11: Kind codes 6 and 7 behave exactly like kind code 2.
- R12: Segment select encoding for `seg_wsel` and `ovr_sel`: 0 = code, 1 = stack, 2 = data, 3 = extra. `ovr_rejected` is low whenever `ovr_req` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_we | input | 1 | Segment base write enable |
| seg_wsel | input | 2 | Segment to write (R12 encoding) |
| seg_wdata | input | 16 | New segment base value |
| ref_kind | input | 3 | Memory reference kind code |
| ref_offset | input | 16 | Offset within the segment |
| ovr_req | input | 1 | Segment override requested |
| ovr_sel | input | 2 | Override segment (R12 encoding) |
| phys_addr | output | 20 | Registered physical byte address |
| ovr_rejected | output | 1 | Registered flag: override refused for a locked kind |

## Verification
The hardest case to reach from the ports is a segment write and a request that depends on that same segment, both landing on one edge. This is the only case that separates old from new base values. Directed cycles pair a write with a request on the written segment, then repeat the request on the following cycle. Random traffic mixes writes to random segments with requests of every kind, including reserved codes, overrides on both legal and locked kinds, and large bases. These large bases trigger the 20-bit wrap.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

   localparam int NUM_SEGS = 4;
   localparam int SEG_IDX_W = 2;
   localparam int KIND_W = 3;

   typedef enum logic [SEG_IDX_W-1:0] {
      SEG_CODE  = 2'd0,
      SEG_STACK = 2'd1,
      SEG_DATA  = 2'd2,
      SEG_EXTRA = 2'd3
   } seg_id_e;

   typedef enum logic [KIND_W-1:0] {
      KIND_FETCH   = 3'd0,
      KIND_STACK   = 3'd1,
      KIND_VAR     = 3'd2,
      KIND_STR_SRC = 3'd3,
      KIND_STR_DST = 3'd4,
      KIND_BP_BASE = 3'd5
   } ref_kind_e;

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
   parameter int SEG_W = 16,
   parameter int NSEG  = 4,
   localparam int IDX_W = $clog2(NSEG)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [IDX_W-1:0]           widx,
   input  logic [SEG_W-1:0]           wdata,
   output logic [NSEG-1:0][SEG_W-1:0] seg_q
);

   for (genvar g = 0; g < NSEG; g++) begin : g_seg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            seg_q[g] <= '0;
         end else if (we && (widx == IDX_W'(g))) begin
            seg_q[g] <= wdata;
         end
      end
   end

endmodule

// File: rtl/seg_route.sv
module seg_route
   import seg_addr_pkg::*;
(
   input  logic [KIND_W-1:0]    kind,
   input  logic                 ovr_req,
   input  logic [SEG_IDX_W-1:0] ovr_sel,
   output logic [SEG_IDX_W-1:0] sel,
   output logic                 reject
);

   logic                 locked;
   logic [SEG_IDX_W-1:0] dflt;

   always_comb begin
      locked = 1'b0;
      dflt   = SEG_DATA;
      case (kind)
         KIND_FETCH:   begin dflt = SEG_CODE;  locked = 1'b1; end
         KIND_STACK:   begin dflt = SEG_STACK; locked = 1'b1; end
         KIND_STR_DST: begin dflt = SEG_EXTRA; locked = 1'b1; end
         KIND_BP_BASE: begin dflt = SEG_STACK; end
         default:      begin dflt = SEG_DATA; end
      endcase
   end

   always_comb begin
      reject = ovr_req && locked;
      sel    = (ovr_req && !locked) ? ovr_sel : dflt;
   end

endmodule

// File: rtl/addr_adder.sv
module addr_adder #(
   parameter int SEG_W     = 16,
   parameter int OFS_W     = 16,
   parameter int SHIFT     = 4,
   parameter int PA_W      = 20,
   parameter bit SPLIT_LOW = 1'b1,
   localparam int HI_W = PA_W - SHIFT
) (
   input  logic [SEG_W-1:0] base,
   input  logic [OFS_W-1:0] ofs,
   output logic [PA_W-1:0]  pa
);

   if (SPLIT_LOW && (SHIFT > 0) && (OFS_W > SHIFT)) begin : g_split
      logic [HI_W-1:0] hi_sum;
      assign hi_sum = HI_W'(base) + HI_W'(ofs[OFS_W-1:SHIFT]);
      assign pa = {hi_sum, ofs[SHIFT-1:0]};
   end else begin : g_full
      logic [SEG_W+SHIFT-1:0] shifted;
      assign shifted = {base, {SHIFT{1'b0}}};
      assign pa = PA_W'(shifted) + PA_W'(ofs);
   end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
   import seg_addr_pkg::*;
#(
   parameter int SEG_W     = 16,
   parameter int OFS_W     = 16,
   parameter int SHIFT     = 4,
   parameter int PA_W      = 20,
   parameter bit SPLIT_LOW = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 seg_we,
   input  logic [1:0]           seg_wsel,
   input  logic [SEG_W-1:0]     seg_wdata,
   input  logic [2:0]           ref_kind,
   input  logic [OFS_W-1:0]     ref_offset,
   input  logic                 ovr_req,
   input  logic [1:0]           ovr_sel,
   output logic [PA_W-1:0]      phys_addr,
   output logic                 ovr_rejected
);

   if (PA_W != SEG_W + SHIFT) begin : g_bad_width
      $error("seg_addr_gen: PA_W must equal SEG_W + SHIFT");
   end
   if (OFS_W > PA_W) begin : g_bad_ofs
      $error("seg_addr_gen: OFS_W wider than PA_W");
   end

   logic [NUM_SEGS-1:0][SEG_W-1:0] seg_q;
   logic [SEG_IDX_W-1:0]           sel;
   logic                           reject;
   logic [PA_W-1:0]                pa_next;

   seg_regfile #(.SEG_W(SEG_W), .NSEG(NUM_SEGS)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (seg_we),
      .widx  (seg_wsel),
      .wdata (seg_wdata),
      .seg_q (seg_q)
   );

   seg_route u_route (
      .kind    (ref_kind),
      .ovr_req (ovr_req),
      .ovr_sel (ovr_sel),
      .sel     (sel),
      .reject  (reject)
   );

   addr_adder #(
      .SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT), .PA_W(PA_W), .SPLIT_LOW(SPLIT_LOW)
   ) u_add (
      .base (seg_q[sel]),
      .ofs  (ref_offset),
      .pa   (pa_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phys_addr    <= '0;
         ovr_rejected <= 1'b0;
      end else begin
         phys_addr    <= pa_next;
         ovr_rejected <= reject;
      end
   end

endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk
   import seg_addr_pkg::*;
#(
   parameter int SEG_W = 16,
   parameter int OFS_W = 16,
   parameter int SHIFT = 4,
   parameter int PA_W  = 20
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           seg_we,
   input logic [1:0]                     seg_wsel,
   input logic [SEG_W-1:0]               seg_wdata,
   input logic [2:0]                     ref_kind,
   input logic [OFS_W-1:0]               ref_offset,
   input logic                           ovr_req,
   input logic [PA_W-1:0]                phys_addr,
   input logic                           ovr_rejected,
   input logic [NUM_SEGS-1:0][SEG_W-1:0] seg_q
);

   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   function automatic logic [PA_W-1:0] form(input logic [SEG_W-1:0] b, input logic [OFS_W-1:0] o);
      logic [SEG_W+SHIFT-1:0] sh;
      sh = {b, {SHIFT{1'b0}}};
      return PA_W'(sh) + PA_W'(o);
   endfunction

   AST_LOW_BITS_PASS: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      1'b1 |=> phys_addr[SHIFT-1:0] == $past(ref_offset[SHIFT-1:0])); // R1

   AST_FETCH_CODE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      ref_kind == KIND_FETCH |=> phys_addr == form($past(seg_q[SEG_CODE]), $past(ref_offset))); // R2

   AST_STACK_LOCKED: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      ref_kind == KIND_STACK |=> phys_addr == form($past(seg_q[SEG_STACK]), $past(ref_offset))); // R3

   AST_DST_EXTRA: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      ref_kind == KIND_STR_DST |=> phys_addr == form($past(seg_q[SEG_EXTRA]), $past(ref_offset))); // R6

   AST_LOCKED_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (ovr_req && (ref_kind == KIND_FETCH || ref_kind == KIND_STACK || ref_kind == KIND_STR_DST))
      |=> ovr_rejected); // R2

   AST_OPEN_NOT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (ref_kind == KIND_VAR || ref_kind == KIND_STR_SRC || ref_kind == KIND_BP_BASE)
      |=> !ovr_rejected); // R4

   AST_NO_REQ_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      !ovr_req |=> !ovr_rejected); // R12

   AST_WRITE_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      seg_we |=> seg_q[$past(seg_wsel)] == $past(seg_wdata)); // R9

endmodule

bind seg_addr_gen seg_addr_gen_chk #(
   .SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT), .PA_W(PA_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .seg_we       (seg_we),
   .seg_wsel     (seg_wsel),
   .seg_wdata    (seg_wdata),
   .ref_kind     (ref_kind),
   .ref_offset   (ref_offset),
   .ovr_req      (ovr_req),
   .phys_addr    (phys_addr),
   .ovr_rejected (ovr_rejected),
   .seg_q        (seg_q)
);

// File: tb/seg_addr_gen_bench.sv
module seg_addr_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        seg_we = 1'b0;
   logic [1:0]  seg_wsel = '0;
   logic [15:0] seg_wdata = '0;
   logic [2:0]  ref_kind = '0;
   logic [15:0] ref_offset = '0;
   logic        ovr_req = 1'b0;
   logic [1:0]  ovr_sel = '0;
   logic [19:0] phys_addr;
   logic        ovr_rejected;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   logic [15:0] model [4];

   always #2.5 clk = ~clk;

   seg_addr_gen u_seg_addr_gen (
      .clk(clk), .rst_n(rst_n), .seg_we(seg_we), .seg_wsel(seg_wsel), .seg_wdata(seg_wdata),
      .ref_kind(ref_kind), .ref_offset(ref_offset), .ovr_req(ovr_req), .ovr_sel(ovr_sel),
      .phys_addr(phys_addr), .ovr_rejected(ovr_rejected)
   );

   // Default base per kind: 0 code,1 stack,2 data,3 extra
   function automatic logic [1:0] dflt_seg(input logic [2:0] k);
      case (k)
         3'd0: return 2'd0;
         3'd1: return 2'd1;
         3'd4: return 2'd3;
         3'd5: return 2'd1;
         default: return 2'd2;
      endcase
   endfunction

   function automatic bit is_locked(input logic [2:0] k);
      return (k == 3'd0) || (k == 3'd1) || (k == 3'd4);
   endfunction

   function automatic string req_of(input logic [2:0] k);
      case (k)
         3'd0: return "R2";
         3'd1: return "R3";
         3'd2: return "R4";
         3'd3: return "R5";
         3'd4: return "R6";
         3'd5: return "R7";
         default: return "R11";
      endcase
   endfunction

   function automatic logic [19:0] exp_pa(input logic [15:0] b, input logic [15:0] o);
      logic [20:0] full;
      full = {1'b0, b, 4'h0} + {5'h0, o};
      return full[19:0];
   endfunction

   task automatic check(input bit ok, input string r, input logic [31:0] act, input logic [31:0] expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", r, act, expv);
      end
   endtask

   task automatic run_cycle(input logic we, input logic [1:0] wsel, input logic [15:0] wd,
                            input logic [2:0] k, input logic ov, input logic [1:0] os,
                            input logic [15:0] of, input string r);
      logic [1:0]  s;
      logic        rej;
      logic [19:0] ea;
      seg_we = we; seg_wsel = wsel; seg_wdata = wd;
      ref_kind = k; ovr_req = ov; ovr_sel = os; ref_offset = of;
      rej = ov && is_locked(k);
      s   = (ov && !is_locked(k)) ? os : dflt_seg(k);
      ea  = exp_pa(model[s], of);
      if (we) model[wsel] = wd;
      @(posedge clk);
      @(negedge clk);
      check(phys_addr == ea, r, 32'(phys_addr), 32'(ea));
      check(ovr_rejected == rej, r, 32'(ovr_rejected), 32'(rej));
   endtask

   initial begin
      for (int i = 0; i < 4; i++) model[i] = '0;
      void'($urandom(32'h5EA1_0C86));
      repeat (3) @(negedge clk);
      // R10: reset state
      check(phys_addr == 20'h0, "R10", 32'(phys_addr), 32'h0);
      check(ovr_rejected == 1'b0, "R10", 32'(ovr_rejected), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: bases cleared, so address equals offset
      run_cycle(1'b0, 2'd0, 16'h0, 3'd2, 1'b0, 2'd0, 16'hBEEF, "R10");
      // Load distinct bases
      run_cycle(1'b1, 2'd0, 16'h1000, 3'd0, 1'b0, 2'd0, 16'h0010, "R12");
      run_cycle(1'b1, 2'd1, 16'h2000, 3'd0, 1'b0, 2'd0, 16'h0020, "R12");
      run_cycle(1'b1, 2'd2, 16'h3000, 3'd0, 1'b0, 2'd0, 16'h0030, "R12");
      run_cycle(1'b1, 2'd3, 16'h4000, 3'd0, 1'b0, 2'd0, 16'h0040, "R12");
      // Each kind, with and without overrides
      run_cycle(1'b0, 2'd0, 16'h0, 3'd0, 1'b1, 2'd2, 16'h1234, "R2");
      run_cycle(1'b0, 2'd0, 16'h0, 3'd1, 1'b1, 2'd3, 16'h1234, "R3");
      run_cycle(1'b0, 2'd0, 16'h0, 3'd2, 1'b1, 2'd3, 16'h0005, "R4");
      run_cycle(1'b0, 2'd0, 16'h0, 3'd3, 1'b0, 2'd0, 16'h0007, "R5");
      run_cycle(1'b0, 2'd0, 16'h0, 3'd3, 1'b1, 2'd0, 16'h0007, "R5");
      run_cycle(1'b0, 2'd0, 16'h0, 3'd4, 1'b1, 2'd2, 16'h0009, "R6");
      run_cycle(1'b0, 2'd0, 16'h0, 3'd5, 1'b0, 2'd0, 16'h000A, "R7");
      run_cycle(1'b0, 2'd0, 16'h0, 3'd5, 1'b1, 2'd2, 16'h000A, "R7");
      run_cycle(1'b0, 2'd0, 16'h0, 3'd6, 1'b1, 2'd1, 16'h000B, "R11");
      run_cycle(1'b0, 2'd0, 16'h0, 3'd7, 1'b0, 2'd0, 16'h000C, "R11");
      // R9: same-edge write sees old base, next request sees new
      run_cycle(1'b1, 2'd2, 16'h5555, 3'd2, 1'b0, 2'd0, 16'h0001, "R9");
      run_cycle(1'b0, 2'd0, 16'h0, 3'd2, 1'b0, 2'd0, 16'h0001, "R9");
      // R8: wrap past 2^20
      run_cycle(1'b1, 2'd3, 16'hFFFF, 3'd0, 1'b0, 2'd0, 16'h0, "R8");
      run_cycle(1'b0, 2'd0, 16'h0, 3'd4, 1'b0, 2'd0, 16'hFFFF, "R8");
      check(phys_addr == 20'h0FFEF, "R8", 32'(phys_addr), 32'h0FFEF);
      // R1: random traffic
      for (int i = 0; i < 400; i++) begin
         logic        w;
         logic [2:0]  k;
         logic        ov;
         w  = ($urandom % 4) == 0;
         k  = 3'($urandom);
         ov = ($urandom % 2) == 1;
         run_cycle(w, 2'($urandom), 16'($urandom), k, ov, 2'($urandom), 16'($urandom),
                   (i % 3 == 0) ? "R1" : req_of(k));
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule